// File: doc/BRIEF.md
# Vectored Nested Priority Interrupt Controller

This block collects up to 32 interrupt lines and presents one request line to a processor. Each source has a mode word and a vector word. The mode word sets the source's priority and whether it is level or edge sensitive. The vector word is the value handed back when that source is acknowledged. Every source line first passes through a two-flop synchroniser. Software controls the enable mask and the pending state through write-only bit-mask command words: one to enable, one to disable, one to set pending and one to clear pending.

Reading the vector word acknowledges a source. The read returns the vector of the best enabled pending source and pushes that source's priority onto an eight-level nesting stack. After that, only a source of strictly higher priority can raise the request line again. A write of any value to the end-of-interrupt word pops one level. When nothing qualifies, the read returns a programmable spurious value.

The register bus is a plain request/response port with no back-pressure. The block accepts `bus_req` on every cycle. Each read raises `rsp_valid` for exactly one cycle, on the cycle after the request, with `rsp_data`. Writes produce no response. `bus_word` is the word address, which is the byte offset divided by four.

Top module: `vic_ctrl`

## Requirements
- R1: After reset, `irq_out` is low, the stack is empty, and the pending, enable, current-source, mode, vector and spurious words all read zero.
- R2: The mode word of source n sits at word n (byte n*4). Bits [6:0] read back exactly as written and bits [31:7] read zero. The vector word of source n sits at word 32+n (byte 0x80+n*4) and reads back all 32 bits.
- R3: Writing byte 0x120 enables, and writing byte 0x124 disables, every source whose bit is 1. A 0 bit leaves that source unchanged. The mask reads back at byte 0x110.
- R4: Writing byte 0x12C with a 1 bit forces that source pending. Writing byte 0x128 with a 1 bit clears it. The pending word reads back at byte 0x10C.
- R5: `irq_out` is high exactly when some enabled pending source has a priority (mode bits [2:0], 7 highest) strictly above the top of the stack, or any priority when the stack is empty.
- R6: A read of byte 0x100 returns the vector of the winning source and pushes it. The winner is the source with the highest priority; on a tie the lower source number wins. Byte 0x108 then reads that source number.
- R7: When nothing qualifies, a read of byte 0x100 returns the word at byte 0x134, does not push, and byte 0x108 then reads zero.
- R8: With mode bits [6:5]=01 (edge), a rising edge on the synchronised input sets pending, and the acknowledge clears it.
- R9: With mode bits [6:5]=00 (level), pending follows the high input level and an acknowledge does not clear it.
- R10: A write of any value to byte 0x130 pops one level, and byte 0x108 returns to the source now on top (zero if empty). On an empty stack the write has no effect.
- R11: The stack holds 8 levels. Eight end-of-interrupt writes always empty it, after which any enabled pending source raises `irq_out`.
- R12: Byte 0x114 reads `irq_out` in bit 1. Byte 0x104, byte 0x138 and unmapped words read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src | input | 32 | Raw interrupt source lines |
| bus_req | input | 1 | Bus access strobe, always accepted |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_word | input | 8 | Word address (byte offset / 4) |
| bus_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read |
| rsp_data | output | 32 | Read data |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
On every cycle, the assertions check the stack depth bound and that each read returns exactly one response. They also check that an acknowledge with a qualifying source grows the stack by one, and that a spurious read or an end-of-interrupt on an empty stack leaves it unchanged. Only the bench scenarios can show the rest. These are the tie-break in favour of the lower source number, the returned vector values, the strict-priority masking while nested, the difference between level and edge pending after an acknowledge, and the current-source number returning to the lower level on each pop.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int MAX_SRC  = 32;
  localparam int VEC_BASE = 32;
  localparam int WORD_W   = 8;
  // word addresses (byte offset / 4)
  localparam logic [WORD_W-1:0] W_ACK  = 8'h40;
  localparam logic [WORD_W-1:0] W_CUR  = 8'h42;
  localparam logic [WORD_W-1:0] W_PEND = 8'h43;
  localparam logic [WORD_W-1:0] W_MASK = 8'h44;
  localparam logic [WORD_W-1:0] W_CORE = 8'h45;
  localparam logic [WORD_W-1:0] W_EN   = 8'h48;
  localparam logic [WORD_W-1:0] W_DIS  = 8'h49;
  localparam logic [WORD_W-1:0] W_CLR  = 8'h4A;
  localparam logic [WORD_W-1:0] W_SET  = 8'h4B;
  localparam logic [WORD_W-1:0] W_EOI  = 8'h4C;
  localparam logic [WORD_W-1:0] W_SPU  = 8'h4D;
  localparam int MODE_EDGE_BIT = 5;
endpackage

// File: rtl/vic_sync.sv
module vic_sync #(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] raw,
  output logic [NUM_SRC-1:0] level,
  output logic [NUM_SRC-1:0] rise
);
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    logic s1_q, s2_q, s3_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
        s3_q <= 1'b0;
      end else begin
        s1_q <= raw[g];
        s2_q <= s1_q;
        s3_q <= s2_q;
      end
    end
    assign level[g] = s2_q;
    assign rise[g]  = s2_q & ~s3_q;
  end
endmodule

// File: rtl/vic_arb.sv
module vic_arb #(
  parameter int NUM_SRC = 32,
  parameter int PRIO_W  = 3,
  localparam int SRC_W  = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0]             qual,
  input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio,
  output logic                           found,
  output logic [SRC_W-1:0]               win_idx,
  output logic [PRIO_W-1:0]              win_prio
);
  always_comb begin
    found    = 1'b0;
    win_idx  = '0;
    win_prio = '0;
    // strictly-greater replacement keeps the lower index on ties
    for (int i = 0; i < NUM_SRC; i++) begin
      if (qual[i] && (!found || prio[i] > win_prio)) begin
        found    = 1'b1;
        win_idx  = SRC_W'(i);
        win_prio = prio[i];
      end
    end
  end
endmodule

// File: rtl/vic_stack.sv
module vic_stack #(
  parameter int DEPTH  = 8,
  parameter int PRIO_W = 3,
  parameter int SRC_W  = 5,
  localparam int DEPTH_W = $clog2(DEPTH + 1),
  localparam int IDX_W   = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               push,
  input  logic               pop,
  input  logic [PRIO_W-1:0]  push_prio,
  input  logic [SRC_W-1:0]   push_src,
  output logic [DEPTH_W-1:0] depth,
  output logic               empty,
  output logic [PRIO_W-1:0]  top_prio,
  output logic [SRC_W-1:0]   under_src
);
  logic [PRIO_W-1:0]  prio_q [DEPTH];
  logic [SRC_W-1:0]   src_q  [DEPTH];
  logic [DEPTH_W-1:0] cnt_q;
  logic [DEPTH_W-1:0] cnt_m1, cnt_m2;
  logic               full;

  assign full   = (cnt_q == DEPTH_W'(DEPTH));
  assign empty  = (cnt_q == '0);
  assign cnt_m1 = cnt_q - DEPTH_W'(1);
  assign cnt_m2 = cnt_q - DEPTH_W'(2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        prio_q[i] <= '0;
        src_q[i]  <= '0;
      end
    end else if (push && !full) begin
      prio_q[cnt_q[IDX_W-1:0]] <= push_prio;
      src_q[cnt_q[IDX_W-1:0]]  <= push_src;
      cnt_q <= cnt_q + DEPTH_W'(1);
    end else if (pop && !empty) begin
      cnt_q <= cnt_m1;
    end
  end

  assign depth     = cnt_q;
  assign top_prio  = empty ? '0 : prio_q[cnt_m1[IDX_W-1:0]];
  assign under_src = (cnt_q >= DEPTH_W'(2)) ? src_q[cnt_m2[IDX_W-1:0]] : '0;
endmodule

// File: rtl/vic_ctrl.sv
module vic_ctrl
  import vic_pkg::*;
#(
  parameter int NUM_SRC   = 32,
  parameter int PRIO_W    = 3,
  parameter int STK_DEPTH = 8,
  parameter int DATA_W    = 32,
  localparam int SRC_W    = $clog2(NUM_SRC),
  localparam int MODE_W   = 7,
  localparam int DEPTH_W  = $clog2(STK_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_src,
  input  logic               bus_req,
  input  logic               bus_we,
  input  logic [WORD_W-1:0]  bus_word,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic               rsp_valid,
  output logic [DATA_W-1:0]  rsp_data,
  output logic               irq_out
);
  logic [MODE_W-1:0]  mode_q [NUM_SRC];
  logic [DATA_W-1:0]  vec_q  [NUM_SRC];
  logic [DATA_W-1:0]  spu_q;
  logic [NUM_SRC-1:0] mask_q, pend_q;
  logic [SRC_W-1:0]   cur_q;

  logic [NUM_SRC-1:0] lvl, rise, is_edge, pend_eff, above, qual;
  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_v;
  logic               found;
  logic [SRC_W-1:0]   win_idx;
  logic [PRIO_W-1:0]  win_prio;
  logic [DEPTH_W-1:0] stk_depth;
  logic               stk_empty;
  logic [PRIO_W-1:0]  top_prio;
  logic [SRC_W-1:0]   under_src;

  logic rd, wr, ack_rd, ack, eoi;
  logic [NUM_SRC-1:0] set_m, clr_m, ack_m, en_m, dis_m;
  logic [DATA_W-1:0]  rd_mux;

  vic_sync #(.NUM_SRC(NUM_SRC)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw(irq_src), .level(lvl), .rise(rise)
  );

  always_comb begin
    for (int i = 0; i < NUM_SRC; i++) begin
      prio_v[i]  = mode_q[i][PRIO_W-1:0];
      is_edge[i] = mode_q[i][MODE_EDGE_BIT];
      above[i]   = stk_empty || (prio_v[i] > top_prio);
    end
  end

  assign pend_eff = pend_q | (lvl & ~is_edge);
  assign qual     = pend_eff & mask_q & above;

  vic_arb #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_arb (
    .qual(qual), .prio(prio_v), .found(found),
    .win_idx(win_idx), .win_prio(win_prio)
  );

  assign rd     = bus_req & ~bus_we;
  assign wr     = bus_req & bus_we;
  assign ack_rd = rd && (bus_word == W_ACK);
  assign ack    = ack_rd && found;
  assign eoi    = wr && (bus_word == W_EOI);

  vic_stack #(.DEPTH(STK_DEPTH), .PRIO_W(PRIO_W), .SRC_W(SRC_W)) u_stack (
    .clk(clk), .rst_n(rst_n), .push(ack), .pop(eoi),
    .push_prio(win_prio), .push_src(win_idx),
    .depth(stk_depth), .empty(stk_empty),
    .top_prio(top_prio), .under_src(under_src)
  );

  assign set_m = (wr && bus_word == W_SET) ? bus_wdata[NUM_SRC-1:0] : '0;
  assign clr_m = (wr && bus_word == W_CLR) ? bus_wdata[NUM_SRC-1:0] : '0;
  assign en_m  = (wr && bus_word == W_EN)  ? bus_wdata[NUM_SRC-1:0] : '0;
  assign dis_m = (wr && bus_word == W_DIS) ? bus_wdata[NUM_SRC-1:0] : '0;
  assign ack_m = ack ? (NUM_SRC'(1) << win_idx) : '0;

  // state updates
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      pend_q <= '0;
      cur_q  <= '0;
      spu_q  <= '0;
    end else begin
      mask_q <= (mask_q & ~dis_m) | en_m;
      // sets win over clears in the same cycle
      pend_q <= (pend_q & ~clr_m & ~ack_m) | set_m | (rise & is_edge);
      if (ack)         cur_q <= win_idx;
      else if (ack_rd) cur_q <= '0;
      else if (eoi)    cur_q <= under_src;
      if (wr && bus_word == W_SPU) spu_q <= bus_wdata;
    end
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_cfg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mode_q[g] <= '0;
        vec_q[g]  <= '0;
      end else if (wr) begin
        if (bus_word == WORD_W'(g))            mode_q[g] <= bus_wdata[MODE_W-1:0];
        if (bus_word == WORD_W'(VEC_BASE + g)) vec_q[g]  <= bus_wdata;
      end
    end
  end

  // read mux
  always_comb begin
    rd_mux = '0;
    if (bus_word < WORD_W'(NUM_SRC)) begin
      rd_mux = DATA_W'(mode_q[bus_word[SRC_W-1:0]]);
    end else if (bus_word >= WORD_W'(VEC_BASE) &&
                 bus_word <  WORD_W'(VEC_BASE + NUM_SRC)) begin
      rd_mux = vec_q[bus_word[SRC_W-1:0]];
    end else begin
      case (bus_word)
        W_ACK:   rd_mux = found ? vec_q[win_idx] : spu_q;
        W_CUR:   rd_mux = DATA_W'(cur_q);
        W_PEND:  rd_mux = DATA_W'(pend_eff);
        W_MASK:  rd_mux = DATA_W'(mask_q);
        W_CORE:  rd_mux = DATA_W'({irq_out, 1'b0});
        W_SPU:   rd_mux = spu_q;
        default: rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rd;
      rsp_data  <= rd ? rd_mux : '0;
    end
  end

  assign irq_out = found;
endmodule

// File: rtl/vic_ctrl_chk.sv
module vic_ctrl_chk #(
  parameter int STK_DEPTH = 8,
  parameter int DEPTH_W   = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_req,
  input logic               bus_we,
  input logic [7:0]         bus_word,
  input logic               rsp_valid,
  input logic               irq_out,
  input logic [DEPTH_W-1:0] depth
);
  logic rd_ack, wr_eoi;
  assign rd_ack = bus_req && !bus_we && bus_word == 8'h40;
  assign wr_eoi = bus_req && bus_we && bus_word == 8'h4C;

  a_r11_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= DEPTH_W'(STK_DEPTH));

  a_r12_read_response: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_we) |=> rsp_valid);

  a_r12_no_stray_response: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_req && !bus_we) |=> !rsp_valid);

  a_r6_ack_pushes: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ack && irq_out && depth != DEPTH_W'(STK_DEPTH)) |=> depth == $past(depth) + DEPTH_W'(1));

  a_r7_spurious_no_push: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ack && !irq_out) |=> $stable(depth));

  a_r10_eoi_pops: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_eoi && depth != '0) |=> depth == $past(depth) - DEPTH_W'(1));

  a_r10_eoi_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_eoi && depth == '0) |=> depth == '0);
endmodule

bind vic_ctrl vic_ctrl_chk #(.STK_DEPTH(STK_DEPTH), .DEPTH_W(DEPTH_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
  .bus_word(bus_word), .rsp_valid(rsp_valid), .irq_out(irq_out),
  .depth(stk_depth)
);

// File: tb/test_vic_ctrl.sv
module test_vic_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_src = '0;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [7:0]  bus_word = '0;
  logic [31:0] bus_wdata = '0;
  logic        rsp_valid, irq_out;
  logic [31:0] rsp_data;

  int checks = 0, errors = 0, cycles = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  localparam logic [7:0] ACK = 8'h40, FVR = 8'h41, CUR = 8'h42, PEND = 8'h43,
    MASK = 8'h44, CORE = 8'h45, EN = 8'h48, DIS = 8'h49, CLR = 8'h4A,
    SETP = 8'h4B, EOI = 8'h4C, SPU = 8'h4D, DBG = 8'h4E;

  vic_ctrl i_vic_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .bus_req(bus_req),
    .bus_we(bus_we), .bus_word(bus_word), .bus_wdata(bus_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .irq_out(irq_out)
  );

  always #4 clk = ~clk;

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  // monitor: compare read responses against the scoreboard queue
  always @(negedge clk) begin
    if (rsp_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL unexpected response: actual %h expected none", rsp_data);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rsp_data !== e) begin
          errors++;
          $display("FAIL %s: actual %h expected %h", t, rsp_data, e);
        end
      end
    end
  end

  task automatic rd(input logic [7:0] w, input logic [31:0] e, input string t);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_word = w;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    bus_req = 1'b0;
  endtask

  task automatic wr(input logic [7:0] w, input logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_word = w; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    @(negedge clk);
    checks++;
    if (irq_out !== e) begin
      errors++;
      $display("FAIL %s irq_out: actual %b expected %b", t, irq_out, e);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    // R1 reset state
    chk_irq(1'b0, "R1");
    rd(PEND, 32'h0, "R1 pending");
    rd(MASK, 32'h0, "R1 mask");
    rd(CUR,  32'h0, "R1 current");
    rd(8'd4, 32'h0, "R1 mode");
    rd(ACK,  32'h0, "R1 spurious");

    // R2 configuration words
    wr(SPU, 32'hDEAD_0000);
    for (int i = 0; i < 32; i++) wr(8'(32 + i), 32'h1000 + i);
    wr(8'd3, 32'hFFFF_FF65);
    rd(8'd3, 32'h0000_0065, "R2 mode readback");
    rd(8'd37, 32'h0000_1005, "R2 vector readback");
    rd(SPU, 32'hDEAD_0000, "R2 spurious word");

    // R3 enable / disable masks
    wr(EN, 32'h0000_00F0);
    wr(DIS, 32'h0000_0030);
    rd(MASK, 32'h0000_00C0, "R3 mask");

    // R4 set / clear pending
    wr(SETP, 32'h0000_0009);
    rd(PEND, 32'h0000_0009, "R4 set");
    chk_irq(1'b0, "R5 disabled pending");
    wr(CLR, 32'h0000_0001);
    rd(PEND, 32'h0000_0008, "R4 clear one");
    wr(CLR, 32'hFFFF_FFFF);
    wr(DIS, 32'hFFFF_FFFF);
    rd(PEND, 32'h0, "R4 clear all");

    // priorities: 1:p2 level, 2:p4 level, 7:p4 level, 9:p6 edge
    wr(8'd1, 32'h02); wr(8'd2, 32'h04); wr(8'd7, 32'h04); wr(8'd9, 32'h26);
    wr(EN, 32'h0000_0286);
    irq_src[1] = 1'b1; irq_src[2] = 1'b1; irq_src[7] = 1'b1;
    idle(4);
    chk_irq(1'b1, "R5 qualifies");
    rd(ACK, 32'h0000_1002, "R6 tie lower number");
    rd(CUR, 32'd2, "R6 current");
    chk_irq(1'b0, "R5 not strictly higher");
    rd(PEND, 32'h0000_0086, "R9 level stays pending");

    // R8 edge source
    irq_src[9] = 1'b1; idle(3); irq_src[9] = 1'b0; idle(4);
    rd(PEND, 32'h0000_0286, "R8 edge pending");
    chk_irq(1'b1, "R5 higher priority nests");
    rd(ACK, 32'h0000_1009, "R6 higher priority");
    rd(CUR, 32'd9, "R6 current nested");
    rd(PEND, 32'h0000_0086, "R8 ack clears edge");

    // R7 spurious
    rd(ACK, 32'hDEAD_0000, "R7 spurious vector");
    rd(CUR, 32'd0, "R7 current zero");

    // R10 unwind
    wr(EOI, 32'h0);
    rd(CUR, 32'd2, "R10 back to lower level");
    chk_irq(1'b0, "R10 still masked");
    wr(EOI, 32'h0);
    chk_irq(1'b1, "R10 released");
    rd(CUR, 32'd0, "R10 empty current");
    rd(ACK, 32'h0000_1002, "R9 level re-acknowledged");
    wr(EOI, 32'h0);
    wr(EOI, 32'h0);
    chk_irq(1'b1, "R10 empty pop no effect");
    rd(ACK, 32'h0000_1002, "R10 push after empty pop");
    rd(CUR, 32'd2, "R10 current");
    wr(EOI, 32'h0);
    irq_src = '0;
    idle(4);
    chk_irq(1'b0, "R9 level released");

    // R11 eight-deep nesting
    wr(DIS, 32'hFFFF_FFFF);
    for (int k = 0; k < 8; k++) wr(8'(10 + k), 32'(k));
    wr(EN, 32'h0003_FC00);
    for (int k = 0; k < 8; k++) begin
      wr(SETP, 32'h1 << (10 + k));
      rd(ACK, 32'h1000 + 10 + k, "R11 nest");
    end
    rd(CUR, 32'd17, "R11 top");
    chk_irq(1'b0, "R11 full stack");
    wr(EOI, 32'h0);
    rd(CUR, 32'd16, "R10 pop once");
    for (int k = 0; k < 7; k++) wr(EOI, 32'h0);
    rd(CUR, 32'd0, "R11 unwound");
    wr(SETP, 32'h0000_1000);
    chk_irq(1'b1, "R11 released after eight");

    // R12 status and unused words
    rd(CORE, 32'h2, "R12 core status");
    rd(FVR, 32'h0, "R12 fast word");
    rd(DBG, 32'h0, "R12 debug word");
    rd(8'h50, 32'h0, "R12 unmapped");

    idle(3);
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL scoreboard: actual %0d outstanding expected 0", exp_q.size());
    end
    summary();
  end
endmodule